// File: doc/BRIEF.md
# Tiled DMA-Compute Pipeline Scheduler

This block runs one composite command. It cuts a payload into tiles, and every tile passes through three stages in order. The first stage is an input transfer on a read-DMA channel. The second is a compute operation on a single compute slot, which is either a matrix multiply or an element-wise operation, and one command uses only one of the two. The third is an output transfer on a write-DMA channel. Each engine is driven through a level request that it acknowledges with a one-cycle done pulse.

The scheduler tracks dependencies per tile. It gives each tile an input and an output staging buffer inside a reserved region of local memory that holds `NBUF` input and `NBUF` output buffers. It pulses a tile-ready strobe as each tile's write finishes, and it raises done together with the strobe of the last tile. Tiles may overlap across engines, but each engine serves one operation at a time.

Top module: `tile_pipe_sched`

## Requirements
- R1: A start with both opcode inputs high, with both low, or with `tile_size` = 0 and a non-zero length is rejected. `reject` pulses in the cycle after start, `done` stays low, `busy` stays low and no engine request is raised.
- R2: A valid start with `payload_len` = 0 pulses `done` in the cycle after start and raises no engine request.
- R3: Reads are issued with `rd_tile` = 0, 1, 2, … in order. `rd_len` equals `tile_size` for every tile except the last, which carries the remainder and may be shorter. The number of reads is ceil(len / tile_size).
- R4: Compute of tile t is requested only after the read of tile t has completed, and tiles are computed in increasing order. `cmp_op` is 0 for the GEMM opcode and 1 for the MATH opcode.
- R5: The write of tile t is requested only after compute of tile t has completed, and tiles are written in increasing order.
- R6: Each of the three channels has capacity 1. A request, together with its tile id, stays high until its done pulse, and drops in the cycle after that pulse. All requests are low after reset.
- R7: The input buffer for tile t is index t mod NBUF, and the output buffer is index NBUF + (t mod NBUF). With NBUF = 2, the input buffers are 0 and 1 and the output buffers are 2 and 3. A read is issued only while fewer than NBUF tiles are held, where a tile is held from the issue of its read until the completion of its write.
- R8: `tile_ready` pulses for one cycle in the cycle after each write completes, with `ready_tile` equal to that tile's id. `done` pulses together with the strobe of the last tile.
- R9: A read of a later tile may run while compute of an earlier tile is in progress. Whenever a command has two or more tiles, a read and a compute are active in the same cycle.
- R10: A start that arrives while `busy` is high is ignored, and the running command completes with its own tile count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | One-cycle command start |
| payload_len | input | LEN_W | Payload length in units |
| tile_size | input | LEN_W | Hardware tile size in units |
| op_gemm | input | 1 | Command requests matrix-multiply compute |
| op_math | input | 1 | Command requests element-wise compute |
| busy | output | 1 | A command is in progress |
| done | output | 1 | Command complete pulse |
| reject | output | 1 | Invalid command pulse |
| tile_ready | output | 1 | Per-tile write-complete strobe |
| ready_tile | output | LEN_W | Tile id for tile_ready |
| rd_req | output | 1 | Read-DMA request |
| rd_tile | output | LEN_W | Tile id of the read |
| rd_len | output | LEN_W | Length of the read |
| rd_buf | output | BW | Input buffer index of the read |
| rd_done | input | 1 | Read-DMA done pulse |
| cmp_req | output | 1 | Compute request |
| cmp_op | output | 1 | 0 GEMM, 1 MATH |
| cmp_tile | output | LEN_W | Tile id of the compute |
| cmp_in_buf | output | BW | Input buffer read by the compute |
| cmp_out_buf | output | BW | Output buffer written by the compute |
| cmp_done | input | 1 | Compute done pulse |
| wr_req | output | 1 | Write-DMA request |
| wr_tile | output | LEN_W | Tile id of the write |
| wr_buf | output | BW | Output buffer index of the write |
| wr_done | input | 1 | Write-DMA done pulse |

## Verification
The assertions check the following on every cycle:
- each request and its tile id stay held until the done pulse, and the request drops after it;
- the number of held tiles never exceeds NBUF;
- `done` never coincides with `reject`;
- the completion of a multi-tile command comes with the tile-ready strobe.

Only the bench's scenarios can show the behaviour that needs a record of the whole command. This covers the in-order tile ids, the remainder length of the last tile, the read-before-compute and compute-before-write ordering, and the buffer indices. It also covers the overlap of reads with compute, the single-cycle answers to zero-length and rejected commands, and a start ignored while busy. The bench shows these over swept lengths, tile sizes, opcodes and engine latencies.

// File: rtl/tps_pkg.sv
package tps_pkg;
    typedef enum logic {
        OP_GEMM = 1'b0,
        OP_MATH = 1'b1
    } cmp_op_e;
endpackage

// File: rtl/tps_tiler.sv
// Length of the next tile from the remaining payload.
module tps_tiler #(
    parameter int LEN_W = 8
) (
    input  logic [LEN_W-1:0] remain,
    input  logic [LEN_W-1:0] tsize,
    output logic [LEN_W-1:0] this_len,
    output logic             is_last
);
    always_comb begin
        is_last  = (remain <= tsize);
        this_len = is_last ? remain : tsize;
    end
endmodule

// File: rtl/tps_buf_pool.sv
// Occupancy of the staging slots; slot k holds input buffer k and output buffer NBUF+k.
module tps_buf_pool #(
    parameter int NBUF   = 2,
    parameter int SLOT_W = $clog2(NBUF)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_en,
    input  logic [SLOT_W-1:0] alloc_slot,
    input  logic              rel_en,
    input  logic [SLOT_W-1:0] rel_slot,
    output logic              slot_free
);
    logic [NBUF-1:0] occ_d, occ_q;

    for (genvar k = 0; k < NBUF; k++) begin : g_slot
        always_comb begin
            occ_d[k] = occ_q[k];
            if (rel_en && rel_slot == SLOT_W'(k))
                occ_d[k] = 1'b0;
            if (alloc_en && alloc_slot == SLOT_W'(k))
                occ_d[k] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) occ_q <= '0;
        else        occ_q <= occ_d;
    end

    assign slot_free = !occ_q[alloc_slot];
endmodule

// File: rtl/tile_pipe_sched.sv
module tile_pipe_sched
    import tps_pkg::*;
#(
    parameter int LEN_W = 8,
    parameter int NBUF  = 2,
    localparam int SW   = $clog2(NBUF),
    localparam int BW   = SW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] payload_len,
    input  logic [LEN_W-1:0] tile_size,
    input  logic             op_gemm,
    input  logic             op_math,
    output logic             busy,
    output logic             done,
    output logic             reject,
    output logic             tile_ready,
    output logic [LEN_W-1:0] ready_tile,
    output logic             rd_req,
    output logic [LEN_W-1:0] rd_tile,
    output logic [LEN_W-1:0] rd_len,
    output logic [BW-1:0]    rd_buf,
    input  logic             rd_done,
    output logic             cmp_req,
    output logic             cmp_op,
    output logic [LEN_W-1:0] cmp_tile,
    output logic [BW-1:0]    cmp_in_buf,
    output logic [BW-1:0]    cmp_out_buf,
    input  logic             cmp_done,
    output logic             wr_req,
    output logic [LEN_W-1:0] wr_tile,
    output logic [BW-1:0]    wr_buf,
    input  logic             wr_done
);
    typedef struct packed {
        logic             busy;
        logic             done;
        logic             reject;
        logic             ready;
        cmp_op_e          op;
        logic [LEN_W-1:0] tsize;
        logic [LEN_W-1:0] remain;
        logic [LEN_W-1:0] last_id;
        logic [LEN_W-1:0] ready_id;
        logic             rd_req;
        logic [LEN_W-1:0] rd_next;
        logic [LEN_W-1:0] rd_tile;
        logic [LEN_W-1:0] rd_len;
        logic [LEN_W-1:0] rd_cnt;
        logic             cmp_req;
        logic [LEN_W-1:0] cmp_next;
        logic [LEN_W-1:0] cmp_tile;
        logic [LEN_W-1:0] cmp_cnt;
        logic             wr_req;
        logic [LEN_W-1:0] wr_next;
        logic [LEN_W-1:0] wr_tile;
    } state_t;

    state_t s_d, s_q;

    logic [LEN_W-1:0] next_len;
    logic             next_last;
    logic             slot_free;
    logic             alloc_en;
    logic             rel_en;
    logic             bad_cmd;

    tps_tiler #(.LEN_W(LEN_W)) u_tiler (
        .remain   (s_q.remain),
        .tsize    (s_q.tsize),
        .this_len (next_len),
        .is_last  (next_last)
    );

    tps_buf_pool #(.NBUF(NBUF), .SLOT_W(SW)) u_pool (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_en   (alloc_en),
        .alloc_slot (s_q.rd_next[SW-1:0]),
        .rel_en     (rel_en),
        .rel_slot   (s_q.wr_tile[SW-1:0]),
        .slot_free  (slot_free)
    );

    assign bad_cmd = (op_gemm == op_math) || (tile_size == '0 && payload_len != '0);

    always_comb begin
        s_d        = s_q;
        s_d.done   = 1'b0;
        s_d.reject = 1'b0;
        s_d.ready  = 1'b0;
        alloc_en   = 1'b0;
        rel_en     = 1'b0;
        if (!s_q.busy) begin
            if (start) begin
                if (bad_cmd) begin
                    s_d.reject = 1'b1;
                end else if (payload_len == '0) begin
                    s_d.done = 1'b1;
                end else begin
                    s_d.busy     = 1'b1;
                    s_d.op       = op_math ? OP_MATH : OP_GEMM;
                    s_d.tsize    = tile_size;
                    s_d.remain   = payload_len;
                    s_d.rd_next  = '0;
                    s_d.rd_cnt   = '0;
                    s_d.cmp_next = '0;
                    s_d.cmp_cnt  = '0;
                    s_d.wr_next  = '0;
                end
            end
        end else begin
            // read channel
            if (s_q.rd_req && rd_done) begin
                s_d.rd_req = 1'b0;
                s_d.rd_cnt = s_q.rd_cnt + 1'b1;
            end else if (!s_q.rd_req && s_q.remain != '0 && slot_free) begin
                alloc_en    = 1'b1;
                s_d.rd_req  = 1'b1;
                s_d.rd_tile = s_q.rd_next;
                s_d.rd_len  = next_len;
                s_d.rd_next = s_q.rd_next + 1'b1;
                s_d.remain  = s_q.remain - next_len;
                if (next_last)
                    s_d.last_id = s_q.rd_next;
            end
            // compute slot
            if (s_q.cmp_req && cmp_done) begin
                s_d.cmp_req = 1'b0;
                s_d.cmp_cnt = s_q.cmp_cnt + 1'b1;
            end else if (!s_q.cmp_req && s_q.cmp_next < s_q.rd_cnt) begin
                s_d.cmp_req  = 1'b1;
                s_d.cmp_tile = s_q.cmp_next;
                s_d.cmp_next = s_q.cmp_next + 1'b1;
            end
            // write channel
            if (s_q.wr_req && wr_done) begin
                rel_en       = 1'b1;
                s_d.wr_req   = 1'b0;
                s_d.ready    = 1'b1;
                s_d.ready_id = s_q.wr_tile;
                if (s_q.remain == '0 && s_q.wr_tile == s_q.last_id) begin
                    s_d.done = 1'b1;
                    s_d.busy = 1'b0;
                end
            end else if (!s_q.wr_req && s_q.wr_next < s_q.cmp_cnt) begin
                s_d.wr_req  = 1'b1;
                s_d.wr_tile = s_q.wr_next;
                s_d.wr_next = s_q.wr_next + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy        = s_q.busy;
    assign done        = s_q.done;
    assign reject      = s_q.reject;
    assign tile_ready  = s_q.ready;
    assign ready_tile  = s_q.ready_id;
    assign rd_req      = s_q.rd_req;
    assign rd_tile     = s_q.rd_tile;
    assign rd_len      = s_q.rd_len;
    assign rd_buf      = {1'b0, s_q.rd_tile[SW-1:0]};
    assign cmp_req     = s_q.cmp_req;
    assign cmp_op      = s_q.op;
    assign cmp_tile    = s_q.cmp_tile;
    assign cmp_in_buf  = {1'b0, s_q.cmp_tile[SW-1:0]};
    assign cmp_out_buf = {1'b1, s_q.cmp_tile[SW-1:0]};
    assign wr_req      = s_q.wr_req;
    assign wr_tile     = s_q.wr_tile;
    assign wr_buf      = {1'b1, s_q.wr_tile[SW-1:0]};
endmodule

// File: rtl/tps_checker.sv
module tps_checker #(
    parameter int LEN_W = 8,
    parameter int NBUF  = 2,
    localparam int CW   = $clog2(NBUF) + 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             reject,
    input logic             tile_ready,
    input logic             rd_req,
    input logic [LEN_W-1:0] rd_tile,
    input logic             rd_done,
    input logic             cmp_req,
    input logic             cmp_op,
    input logic [LEN_W-1:0] cmp_tile,
    input logic             cmp_done,
    input logic             wr_req,
    input logic [LEN_W-1:0] wr_tile,
    input logic             wr_done
);
    logic          rd_req_prev;
    logic [CW-1:0] held;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_req_prev <= 1'b0;
            held        <= '0;
        end else begin
            rd_req_prev <= rd_req;
            held <= held + CW'(rd_req && !rd_req_prev) - CW'(wr_req && wr_done);
        end
    end

    assert_rd_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !rd_done |=> rd_req && $stable(rd_tile));
    assert_rd_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && rd_done |=> !rd_req);
    assert_cmp_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_req && !cmp_done |=> cmp_req && $stable(cmp_tile) && $stable(cmp_op));
    assert_wr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req && !wr_done |=> wr_req && $stable(wr_tile));
    assert_wr_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req && wr_done |=> !wr_req && tile_ready);
    assert_held_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        held <= CW'(NBUF));
    assert_no_done_reject_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && reject));
    assert_reject_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        reject |-> !busy && !rd_req);
    assert_done_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done && $past(busy) |-> tile_ready);
    assert_start_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start && busy |=> !reject);
endmodule

bind tile_pipe_sched tps_checker #(.LEN_W(LEN_W), .NBUF(NBUF)) u_chk (.*);

// File: tb/test_tile_pipe_sched.sv
module test_tile_pipe_sched;
    localparam int LW = 8;
    localparam int NB = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [LW-1:0] payload_len = '0, tile_size = '0;
    logic op_gemm = 1'b0, op_math = 1'b0;
    logic busy, done, reject, tile_ready;
    logic [LW-1:0] ready_tile;
    logic rd_req, cmp_req, wr_req, cmp_op;
    logic [LW-1:0] rd_tile, rd_len, cmp_tile, wr_tile;
    logic [1:0] rd_buf, cmp_in_buf, cmp_out_buf, wr_buf;
    logic rd_done = 1'b0, cmp_done = 1'b0, wr_done = 1'b0;

    always #4 clk = ~clk;

    tile_pipe_sched #(.LEN_W(LW), .NBUF(NB)) i_tile_pipe_sched (.*);

    int checks = 0, errors = 0;
    int c_len, c_ts, c_op;
    int rl = 1, cl = 1, wl = 1;
    int n_rd, n_rdd, n_cmp, n_cmpd, n_wr, n_wrd, n_ready, n_done, n_rej, n_req;
    bit overlap;
    int rcnt, ccnt, wcnt;
    bit prd, pcmp, pwr;

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_req && cmp_req) overlap = 1;
            if (rd_req && !prd) begin
                int rem;
                rem = c_len - n_rd * c_ts;
                n_req++;
                chk(rd_tile == LW'(n_rd), "R3 rd_tile", int'(rd_tile), n_rd);
                chk(rd_len == LW'(rem < c_ts ? rem : c_ts), "R3 rd_len", int'(rd_len), rem < c_ts ? rem : c_ts);
                chk(rd_buf == 2'(n_rd % NB), "R7 rd_buf", int'(rd_buf), n_rd % NB);
                chk(n_rd - n_wrd < NB, "R7 held", n_rd - n_wrd, NB - 1);
                n_rd++;
            end
            if (cmp_req && !pcmp) begin
                n_req++;
                chk(cmp_tile == LW'(n_cmp), "R4 cmp_tile", int'(cmp_tile), n_cmp);
                chk(n_cmp < n_rdd, "R4 after read", n_rdd, n_cmp + 1);
                chk(cmp_op == c_op[0], "R4 cmp_op", int'(cmp_op), c_op);
                chk(cmp_in_buf == 2'(n_cmp % NB) && cmp_out_buf == 2'(NB + n_cmp % NB),
                    "R7 cmp bufs", int'(cmp_out_buf), NB + n_cmp % NB);
                n_cmp++;
            end
            if (wr_req && !pwr) begin
                n_req++;
                chk(wr_tile == LW'(n_wr), "R5 wr_tile", int'(wr_tile), n_wr);
                chk(n_wr < n_cmpd, "R5 after compute", n_cmpd, n_wr + 1);
                chk(wr_buf == 2'(NB + n_wr % NB), "R7 wr_buf", int'(wr_buf), NB + n_wr % NB);
                n_wr++;
            end
            if (tile_ready) begin
                chk(ready_tile == LW'(n_ready) && n_ready < n_wrd, "R8 ready_tile", int'(ready_tile), n_ready);
                n_ready++;
            end
            if (done) n_done++;
            if (reject) n_rej++;
            prd = rd_req; pcmp = cmp_req; pwr = wr_req;
            // responders
            rd_done = 0; cmp_done = 0; wr_done = 0;
            if (rd_req) begin rcnt++; if (rcnt >= rl) begin rd_done = 1; rcnt = 0; n_rdd++; end end
            if (cmp_req) begin ccnt++; if (ccnt >= cl) begin cmp_done = 1; ccnt = 0; n_cmpd++; end end
            if (wr_req) begin wcnt++; if (wcnt >= wl) begin wr_done = 1; wcnt = 0; n_wrd++; end end
        end
    end

    task automatic clear_sb();
        n_rd = 0; n_rdd = 0; n_cmp = 0; n_cmpd = 0; n_wr = 0; n_wrd = 0;
        n_ready = 0; n_done = 0; n_rej = 0; n_req = 0; overlap = 0;
        rcnt = 0; ccnt = 0; wcnt = 0;
    endtask

    task automatic run_cmd(int len, int ts, bit g, bit m, bit inject);
        int n;
        n = (len == 0) ? 0 : (len + ts - 1) / ts;
        clear_sb();
        c_len = len; c_ts = ts; c_op = m ? 1 : 0;
        @(negedge clk);
        payload_len = LW'(len); tile_size = LW'(ts); op_gemm = g; op_math = m; start = 1;
        @(negedge clk); #1;
        start = 0;
        if (len == 0) begin
            chk(n_done == 1 && n_req == 0, "R2 zero length done", n_done, 1);
        end else begin
            if (inject) begin
                repeat (5) @(negedge clk);
                payload_len = 3; tile_size = 1; start = 1;
                @(negedge clk); start = 0;
            end
            for (int i = 0; i < 3000 && n_done == 0; i++) @(negedge clk);
            #1;
            @(negedge clk); #1;
            chk(n_done == 1, "R8 single done", n_done, 1);
            chk(n_ready == n, "R8 ready count", n_ready, n);
            chk(n_rd == n, inject ? "R10 tiles kept" : "R3 read count", n_rd, n);
            chk(n_wr == n && n_cmp == n, "R5 write count", n_wr, n);
            if (n >= 2) chk(overlap, "R9 read/compute overlap", int'(overlap), 1);
        end
        chk(!busy, "R8 idle after done", int'(busy), 0);
    endtask

    task automatic run_bad(int len, int ts, bit g, bit m);
        clear_sb();
        @(negedge clk);
        payload_len = LW'(len); tile_size = LW'(ts); op_gemm = g; op_math = m; start = 1;
        @(negedge clk); #1;
        start = 0;
        chk(n_rej == 1 && !busy, "R1 reject pulse", n_rej, 1);
        repeat (4) @(negedge clk);
        #1;
        chk(n_req == 0 && n_done == 0 && n_rej == 1, "R1 no activity", n_req, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        clear_sb();
        prd = 0; pcmp = 0; pwr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk); #1;
        chk(!busy && !done && !rd_req && !cmp_req && !wr_req && !tile_ready, "R6 reset idle",
            int'(busy), 0);
        run_bad(5, 2, 1, 1);
        run_bad(5, 2, 0, 0);
        run_bad(5, 0, 1, 0);
        run_bad(0, 3, 1, 1);
        for (int ln = 0; ln <= 9; ln++) begin
            for (int ts = 1; ts <= 4; ts++) begin
                for (int op = 0; op < 2; op++) begin
                    rl = (ln + ts) % 3 + 1;
                    cl = (ln + op) % 4 + 1;
                    wl = (ts + op) % 3 + 1;
                    run_cmd(ln, ts, op == 0, op == 1, 0);
                end
            end
        end
        rl = 1; cl = 4; wl = 1;
        run_cmd(7, 7, 1, 0, 0);
        run_cmd(7, 8, 0, 1, 0);
        rl = 2; cl = 3; wl = 2;
        run_cmd(8, 2, 1, 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule